// File: doc/BRIEF.md
# Host-to-Local Address Window Translator

This block maps addresses that a host issues into its firmware address space onto a local memory address space, through one programmable window with 64 KiB granularity. A narrow register-write port loads the window. There are three word registers: an enable control word, a base word and a mask word. A translation port takes a host address with a valid strobe. It returns a hit flag and the translated local address.

The base word holds two upper halves. The high half is the local (target) upper address and the low half is the host-side upper address. The mask word also holds two halves. The high half selects upper address bits that are replaced from the local base. The low half selects upper address bits that are carried over from the request. The lower 16 address bits always pass through unchanged. By default the result is registered, so it appears one cycle after the request. A parameter selects a purely combinational path instead.

Top module: `win_xlate_top`

## Requirements
- R1: After reset the enable bits, the base word and the mask word are all zero, so every request misses with rsp_hit 0 and rsp_addr 0.
- R2: A request can hit only when control bit 8 and control bit 10 are both set in the last control write (word offset 0x0); either bit alone gives a miss.
- R3: A request hits when, for every bit i in 0..15 whose keep-mask bit (mask word bit i, offset 0xC) is 0, request address bit 16+i equals host base bit i (base word bit i, offset 0x8).
- R4: On a hit, local address bit 16+i is base word bit 16+i where mask bit 16+i is 1. Otherwise it is request bit 16+i where mask bit i is 1, and otherwise it is 0. The replace bit wins when both mask bits are set.
- R5: On a hit, local address bits [15:0] equal request address bits [15:0].
- R6: On a miss, rsp_hit is 0 and rsp_addr is 0.
- R7: In the default registered variant, rsp_valid is high exactly one cycle after req_valid and carries that request's result. While rsp_valid is low, rsp_hit and rsp_addr are 0.
- R8: A write to any offset other than 0x0, 0x8 and 0xC changes no register, so later translations are unchanged.
- R9: A register write takes effect at the clock edge that captures it. A request presented in the same cycle as the write uses the old contents. A request in the following cycle uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_off | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Host firmware-space address |
| rsp_valid | output | 1 | Translation result valid |
| rsp_hit | output | 1 | Address fell inside the window |
| rsp_addr | output | 32 | Translated local address, 0 on a miss |

## Verification
Each translation result is due exactly one clock after the cycle in which its request is presented. Register writes affect requests from the cycle after the write, and never a request presented in the same cycle. The driver drives inputs on the falling edge and pushes each expected result into a queue, computed from its own model of the registers as they stood in the cycle of the request. The monitor samples 1 ns after each rising edge, pops one entry for every cycle in which rsp_valid is high, and checks that the outputs are zero in every other cycle. Because of this, any extra or missing cycle of latency shows up as a mismatch.

// File: rtl/win_pkg.sv
package win_pkg;
   localparam int HALF_W = 16;
   localparam int WORD_W = 2 * HALF_W;

   typedef struct packed {
      logic [HALF_W-1:0] local_hi;
      logic [HALF_W-1:0] host_hi;
   } win_base_t;

   typedef struct packed {
      logic [HALF_W-1:0] replace;
      logic [HALF_W-1:0] keep;
   } win_mask_t;
endpackage

// File: rtl/win_regs.sv
module win_regs
   import win_pkg::*;
#(
   parameter int OFF_W    = 8,
   parameter int OFF_CTRL = 'h0,
   parameter int OFF_BASE = 'h8,
   parameter int OFF_MASK = 'hC,
   parameter int EN_A_BIT = 8,
   parameter int EN_B_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [OFF_W-1:0]  off,
   input  logic [WORD_W-1:0] wdata,
   output logic              win_en,
   output win_base_t         base_q,
   output win_mask_t         mask_q
);
   localparam logic [OFF_W-1:0] SEL_C = OFF_W'(OFF_CTRL);
   localparam logic [OFF_W-1:0] SEL_B = OFF_W'(OFF_BASE);
   localparam logic [OFF_W-1:0] SEL_M = OFF_W'(OFF_MASK);

   initial begin
      assert (EN_A_BIT < WORD_W && EN_B_BIT < WORD_W && EN_A_BIT != EN_B_BIT)
         else $error("win_regs: enable bit positions invalid");
      assert (OFF_CTRL != OFF_BASE && OFF_CTRL != OFF_MASK && OFF_BASE != OFF_MASK)
         else $error("win_regs: offsets must differ");
      assert (OFF_MASK < (1 << OFF_W) && OFF_BASE < (1 << OFF_W) && OFF_CTRL < (1 << OFF_W))
         else $error("win_regs: offset exceeds decode width");
   end

   logic       hit_c, hit_b, hit_m;
   logic [1:0] en_q;

   assign hit_c = we && (off == SEL_C);
   assign hit_b = we && (off == SEL_B);
   assign hit_m = we && (off == SEL_M);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= '0;
         base_q <= '0;
         mask_q <= '0;
      end else begin
         if (hit_c) en_q   <= {wdata[EN_B_BIT], wdata[EN_A_BIT]};
         if (hit_b) base_q <= win_base_t'(wdata);
         if (hit_m) mask_q <= win_mask_t'(wdata);
      end
   end

   assign win_en = &en_q;

   AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !hit_c && !hit_b && !hit_m) |=> ($stable(base_q) && $stable(mask_q) && $stable(win_en))) // R8
      else $error("stray write changed a register");

   AST_BASE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_b |=> (base_q == $past(wdata))) // R9
      else $error("base write not visible next cycle");

   AST_MASK_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      hit_m |=> (mask_q == $past(wdata))) // R9
      else $error("mask write not visible next cycle");
endmodule

// File: rtl/win_match.sv
module win_match #(
   parameter int UW = 16
) (
   input  logic          en,
   input  logic [UW-1:0] up,
   input  logic [UW-1:0] host_hi,
   input  logic [UW-1:0] keep,
   output logic          hit
);
   logic [UW-1:0] diff;

   for (genvar i = 0; i < UW; i++) begin : g_bit
      assign diff[i] = ~keep[i] & (up[i] ^ host_hi[i]);
   end

   assign hit = en & ~|diff;
endmodule

// File: rtl/win_remap.sv
module win_remap #(
   parameter int UW = 16
) (
   input  logic [UW-1:0] up,
   input  logic [UW-1:0] local_hi,
   input  logic [UW-1:0] replace,
   input  logic [UW-1:0] keep,
   output logic [UW-1:0] mapped
);
   for (genvar i = 0; i < UW; i++) begin : g_bit
      assign mapped[i] = replace[i] ? local_hi[i] : (keep[i] & up[i]);
   end
endmodule

// File: rtl/win_xlate_top.sv
module win_xlate_top
   import win_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRAN_LOG2 = 16,
   parameter int OFF_W     = 8,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [OFF_W-1:0]  cfg_off,
   input  logic [WORD_W-1:0] cfg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [ADDR_W-1:0] rsp_addr
);
   localparam int UW = ADDR_W - GRAN_LOG2;

   initial begin
      assert (UW == HALF_W && GRAN_LOG2 > 0)
         else $error("win_xlate_top: upper field must match register half width");
   end

   logic              win_en;
   win_base_t         base_q;
   win_mask_t         mask_q;
   logic              hit_c;
   logic [UW-1:0]     up_c, mapped_c;
   logic [ADDR_W-1:0] addr_c;

   win_regs #(.OFF_W(OFF_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .off    (cfg_off),
      .wdata  (cfg_wdata),
      .win_en (win_en),
      .base_q (base_q),
      .mask_q (mask_q)
   );

   assign up_c = req_addr[ADDR_W-1:GRAN_LOG2];

   win_match #(.UW(UW)) u_match (
      .en      (win_en),
      .up      (up_c),
      .host_hi (base_q.host_hi),
      .keep    (mask_q.keep),
      .hit     (hit_c)
   );

   win_remap #(.UW(UW)) u_remap (
      .up       (up_c),
      .local_hi (base_q.local_hi),
      .replace  (mask_q.replace),
      .keep     (mask_q.keep),
      .mapped   (mapped_c)
   );

   assign addr_c = (req_valid && hit_c) ? {mapped_c, req_addr[GRAN_LOG2-1:0]} : '0;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_addr  <= '0;
         end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && hit_c;
            rsp_addr  <= addr_c;
         end
      end

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> rsp_valid) // R7
         else $error("response missing one cycle after request");

      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !rsp_valid |-> (!rsp_hit && rsp_addr == '0)) // R7
         else $error("outputs active without valid");

      AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !rsp_hit |-> (rsp_addr == '0)) // R6
         else $error("miss drove a nonzero address");

      AST_HIT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_hit |-> $past(win_en)) // R2
         else $error("hit while window disabled");

      AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_hit |-> (rsp_addr[GRAN_LOG2-1:0] == $past(req_addr[GRAN_LOG2-1:0]))) // R5
         else $error("low address bits altered");
   end else begin : g_comb
      assign rsp_valid = req_valid;
      assign rsp_hit   = req_valid && hit_c;
      assign rsp_addr  = addr_c;

      AST_MISS_ZERO_C: assert property (@(posedge clk) disable iff (!rst_n)
         !rsp_hit |-> (rsp_addr == '0)) // R6
         else $error("miss drove a nonzero address");

      AST_HIT_NEEDS_EN_C: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_hit |-> win_en) // R2
         else $error("hit while window disabled");
   end
endmodule

// File: tb/sim_win_xlate_top.sv
`timescale 1ns/1ps
module sim_win_xlate_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [7:0]  cfg_off = '0;
   logic [31:0] cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        rsp_valid, rsp_hit;
   logic [31:0] rsp_addr;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;
   bit mon_on  = 1'b0;

   typedef struct {
      logic        hit;
      logic [31:0] addr;
      string       tag;
   } exp_t;
   exp_t sb[$];

   // bench model of the registers
   logic        m_en = 1'b0;
   logic [31:0] m_base = '0;
   logic [31:0] m_mask = '0;

   always #2.5 clk = ~clk;

   win_xlate_top u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_off(cfg_off),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr)
   );

   function automatic exp_t predict(logic [31:0] a, string tag);
      exp_t e;
      logic [15:0] up, keep, rep, lu;
      up   = a[31:16];
      keep = m_mask[15:0];
      rep  = m_mask[31:16];
      e.tag = tag;
      e.hit = m_en && ((up & ~keep) == (m_base[15:0] & ~keep));
      lu    = (m_base[31:16] & rep) | (up & keep & ~rep);
      e.addr = e.hit ? {lu, a[15:0]} : 32'h0;
      return e;
   endfunction

   task automatic model_write(logic [7:0] off, logic [31:0] d);
      if (off == 8'h00) m_en = d[8] & d[10];
      else if (off == 8'h08) m_base = d;
      else if (off == 8'h0C) m_mask = d;
   endtask

   task automatic cycle_drive(bit we, logic [7:0] off, logic [31:0] d, bit rv, logic [31:0] a, string tag);
      @(negedge clk);
      cfg_we = we; cfg_off = off; cfg_wdata = d;
      req_valid = rv; req_addr = a;
      if (rv) sb.push_back(predict(a, tag));   // old contents apply (R9)
      if (we) model_write(off, d);
   endtask

   task automatic wr(logic [7:0] off, logic [31:0] d);
      cycle_drive(1'b1, off, d, 1'b0, 32'h0, "");
   endtask

   task automatic rq(logic [31:0] a, string tag);
      cycle_drive(1'b0, 8'h0, 32'h0, 1'b1, a, tag);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cycle_drive(1'b0, 8'h0, 32'h0, 1'b0, 32'h0, "");
   endtask

   task automatic expect_lit(logic [31:0] a, logic h, logic [31:0] ea, string tag);
      exp_t e;
      e = predict(a, tag);
      vectors++;
      if (e.hit !== h || e.addr !== ea) begin
         fails++;
         $display("FAIL %s model hit=%0b addr=%h expected hit=%0b addr=%h", tag, e.hit, e.addr, h, ea);
      end
      rq(a, tag);
   endtask

   // monitor: pops one expected item per valid response
   initial begin
      exp_t e;
      forever begin
         @(posedge clk); #1;
         if (mon_on) begin
            vectors++;
            if (rsp_valid) begin
               if (sb.size() == 0) begin
                  fails++;
                  $display("FAIL R7 unexpected response hit=%0b addr=%h expected none", rsp_hit, rsp_addr);
               end else begin
                  e = sb.pop_front();
                  if (rsp_hit !== e.hit || rsp_addr !== e.addr) begin
                     fails++;
                     $display("FAIL %s hit=%0b addr=%h expected hit=%0b addr=%h",
                              e.tag, rsp_hit, rsp_addr, e.hit, e.addr);
                  end
               end
            end else if (rsp_hit !== 1'b0 || rsp_addr !== 32'h0) begin
               fails++;
               $display("FAIL R7 idle outputs hit=%0b addr=%h expected hit=0 addr=00000000", rsp_hit, rsp_addr);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired, run hung");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, outputs quiet and everything misses
      @(posedge clk); #1;
      vectors++;
      if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_addr !== 32'h0) begin
         fails++;
         $display("FAIL R1 after reset valid=%0b hit=%0b addr=%h expected 0 0 00000000", rsp_valid, rsp_hit, rsp_addr);
      end
      mon_on = 1'b1;
      expect_lit(32'h1234_5678, 1'b0, 32'h0, "R1");
      expect_lit(32'h0000_0000, 1'b0, 32'h0, "R1");

      // 1 MiB window: local 0x8000xxxx, host 0x0E00xxxx
      wr(8'h08, 32'h8000_0E00);
      wr(8'h0C, 32'hFFF0_000F);
      expect_lit(32'h0E03_1234, 1'b0, 32'h0, "R2");    // no enable yet
      wr(8'h00, 32'h0000_0100);
      expect_lit(32'h0E03_1234, 1'b0, 32'h0, "R2");    // bit 8 only
      wr(8'h00, 32'h0000_0400);
      expect_lit(32'h0E03_1234, 1'b0, 32'h0, "R2");    // bit 10 only
      wr(8'h00, 32'h0000_0500);
      expect_lit(32'h0E03_1234, 1'b1, 32'h8003_1234, "R3");
      expect_lit(32'h0E0F_FFFF, 1'b1, 32'h800F_FFFF, "R5");
      expect_lit(32'h0E00_0000, 1'b1, 32'h8000_0000, "R4");
      expect_lit(32'h0E10_0000, 1'b0, 32'h0, "R6");
      expect_lit(32'h0F03_0000, 1'b0, 32'h0, "R6");
      idle(2);

      // R8: stray offsets ignored
      wr(8'h04, 32'hFFFF_FFFF);
      wr(8'h10, 32'h0000_0000);
      wr(8'h0D, 32'h0000_0000);
      expect_lit(32'h0E07_00AA, 1'b1, 32'h8007_00AA, "R8");

      // R9: write and request in the same cycle use old contents
      cycle_drive(1'b1, 8'h00, 32'h0, 1'b1, 32'h0E02_0002, "R9");
      expect_lit(32'h0E02_0002, 1'b0, 32'h0, "R9");     // next cycle: disabled
      cycle_drive(1'b1, 8'h00, 32'h0000_0500, 1'b1, 32'h0E02_0003, "R9");
      expect_lit(32'h0E02_0003, 1'b1, 32'h8002_0003, "R9");

      // R4: bits in neither mask read 0
      wr(8'h08, 32'h80A0_0E30);
      wr(8'h0C, 32'hFF00_000F);
      expect_lit(32'h0E35_ABCD, 1'b1, 32'h8005_ABCD, "R4");
      expect_lit(32'h0E45_ABCD, 1'b0, 32'h0, "R3");
      // R4: replace wins where both masks set
      wr(8'h08, 32'h1234_0E30);
      wr(8'h0C, 32'h00FF_000F);
      expect_lit(32'h0E35_0001, 1'b1, 32'h0034_0001, "R4");

      // R3: full keep mask accepts every address unchanged
      wr(8'h0C, 32'h0000_FFFF);
      for (int i = 0; i < 6; i++)
         expect_lit(32'h1357_9BDF * (i + 1), 1'b1, 32'h1357_9BDF * (i + 1), "R3");

      // R7: back-to-back stream, mixed hits and misses
      wr(8'h0C, 32'hFFFF_0000);
      wr(8'h08, 32'hC000_0042);
      for (int i = 0; i < 8; i++) rq({16'h0042 ^ 16'(i & 1), 16'(i * 257)}, "R7");
      idle(3);
      vectors++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R7 pending=%0d expected 0", sb.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule